// File: doc/BRIEF.md
# Data Address Generator with DSP Addressing Modes

This block is the address arithmetic unit that sits beside the load/store path of a signal-processing core. For every memory request it takes a pointer value, a signed stride, a signed immediate offset, the base and length of a circular buffer, an access size code and a mode code. From these it produces two things in the same step: the address that goes to memory and the new pointer value that is written back to the pointer register.

Eight modes cover the addressing styles that DSP inner loops rely on. There is plain indirect access. There are post-increment and post-decrement by the access size. There is post-modify by an arbitrary signed stride. There is a circular post-modify that keeps the pointer inside a buffer. There is a post-modify with reversed carry for FFT index order. There is indexed access through a signed immediate. Finally, there is a stack push that decrements the pointer before use.

The result is registered. A request presented in one clock cycle returns its address and updated pointer in the next cycle, so a pointer update costs a single cycle.

Top module: `addr_gen`

## Requirements
- R1: One clock after a cycle with `req_valid_i` high, `rsp_valid_o` is high and carries that request's results. In a cycle after a cycle with `req_valid_i` low, `rsp_valid_o` is low and `addr_o`/`ptr_wb_o` keep their previous values.
- R2: While `rst_n` is low, `rsp_valid_o`, `addr_o` and `ptr_wb_o` are all zero.
- R3: Mode code 0 (indirect): the address equals the pointer, and the written-back pointer equals the pointer.
- R4: Mode codes 1 and 2 (post-increment and post-decrement): the address equals the pointer, and the new pointer is the pointer plus or minus the access size. The access size comes from `size_i`: code 0 is 1 byte, code 1 is 2 bytes, and codes 2 and 3 are 4 bytes.
- R5: Mode code 3 (post-modify): the address equals the pointer, and the new pointer is the pointer plus the signed two's-complement `stride_i`, modulo 2^32.
- R6: Mode code 4 (circular): the address equals the pointer. Let S = pointer + stride and E = base + length. If S ≥ E, the new pointer is S − length. If S < base, it is S + length. Otherwise it is S. A result exactly equal to E therefore wraps to the base. This assumes the pointer lies in the buffer and |stride| ≤ length.
- R7: Mode code 4 with `length_i` equal to 0 applies no wrap: the new pointer is pointer + stride.
- R8: Mode code 5 (bit-reversed): the address equals the pointer. The new pointer is the sum of pointer and stride with the carry moving from bit 31 toward bit 0, and any carry out of bit 0 is dropped.
- R9: Mode code 6 (indexed): the address is the pointer plus the signed `offset_i`, and the pointer is written back unchanged.
- R10: Mode code 7 (stack push): both the address and the new pointer equal the pointer minus the access size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid_i | input | 1 | A request is present this cycle |
| mode_i | input | 3 | Addressing mode code (0..7, see requirements) |
| size_i | input | 2 | Access size code (0: 1 B, 1: 2 B, 2/3: 4 B) |
| ptr_i | input | 32 | Current pointer value |
| stride_i | input | 32 | Signed modify value for modes 3, 4 and 5 |
| offset_i | input | 32 | Signed immediate offset for mode 6 |
| base_i | input | 32 | Circular buffer start address |
| length_i | input | 32 | Circular buffer length in bytes, 0 disables wrap |
| rsp_valid_o | output | 1 | Results of the previous cycle's request are valid |
| addr_o | output | 32 | Effective memory address |
| ptr_wb_o | output | 32 | Updated pointer value for write-back |

## Verification
The linear modes are driven with each size code, and post-modify is driven with a negative stride. These runs separate correct size decoding and sign handling from a design that ignores the size or the sign. Circular mode is tried in five cases:
- a step past the end;
- a step that lands exactly on the end;
- a backward step below the base;
- a step that lands exactly on the base;
- a zero length.

Together these expose off-by-one errors in each wrap comparison. The bit-reversed mode is chained through a full eight-point FFT order and back to zero, which only a carry moving toward bit 0 produces. Indexed and push modes show whether the address and the pointer are taken before or after the change.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        AGU_IND  = 3'd0,
        AGU_INC  = 3'd1,
        AGU_DEC  = 3'd2,
        AGU_MOD  = 3'd3,
        AGU_CIRC = 3'd4,
        AGU_BREV = 3'd5,
        AGU_IDX  = 3'd6,
        AGU_PUSH = 3'd7
    } agu_mode_e;

    // Access size code to byte count.
    function automatic logic [3:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    size_bytes = 4'd1;
            2'd1:    size_bytes = 4'd2;
            default: size_bytes = 4'd4;
        endcase
    endfunction

endpackage

// File: rtl/agu_circ_wrap.sv
module agu_circ_wrap #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] ptr_i,
    input  logic [AW-1:0] stride_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] length_i,
    output logic [AW-1:0] next_o
);
    logic [AW-1:0] sum;
    logic [AW-1:0] lim;

    always_comb begin
        sum = ptr_i + stride_i;
        lim = base_i + length_i;
        if (length_i == '0) begin
            next_o = sum;
        end else if (sum >= lim) begin
            next_o = sum - length_i;
        end else if (sum < base_i) begin
            next_o = sum + length_i;
        end else begin
            next_o = sum;
        end
    end
endmodule

// File: rtl/agu_rev_add.sv
module agu_rev_add #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] a_i,
    input  logic [AW-1:0] b_i,
    output logic [AW-1:0] sum_o
);
    logic [AW-1:0] a_r;
    logic [AW-1:0] b_r;
    logic [AW-1:0] s_r;

    // Mirror the operands so that an ordinary adder carries toward bit 0.
    for (genvar i = 0; i < AW; i++) begin : g_mirror
        assign a_r[i]   = a_i[AW-1-i];
        assign b_r[i]   = b_i[AW-1-i];
        assign sum_o[i] = s_r[AW-1-i];
    end

    assign s_r = a_r + b_r;
endmodule

// File: rtl/addr_gen.sv
module addr_gen #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid_i,
    input  logic [2:0]    mode_i,
    input  logic [1:0]    size_i,
    input  logic [AW-1:0] ptr_i,
    input  logic [AW-1:0] stride_i,
    input  logic [AW-1:0] offset_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] length_i,
    output logic          rsp_valid_o,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] ptr_wb_o
);
    import agu_pkg::*;

    localparam int SZW = 4;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [AW-1:0] ptr;
    } agu_state_t;

    agu_state_t    st_d, st_q;
    logic [AW-1:0] circ_next;
    logic [AW-1:0] brev_next;
    logic [AW-1:0] step;
    agu_mode_e     mode;

    agu_circ_wrap #(.AW(AW)) circ_i (
        .ptr_i    (ptr_i),
        .stride_i (stride_i),
        .base_i   (base_i),
        .length_i (length_i),
        .next_o   (circ_next)
    );

    agu_rev_add #(.AW(AW)) brev_i (
        .a_i   (ptr_i),
        .b_i   (stride_i),
        .sum_o (brev_next)
    );

    always_comb begin
        mode = agu_mode_e'(mode_i);
        step = {{(AW-SZW){1'b0}}, size_bytes(size_i)};
        st_d = st_q;
        st_d.vld = req_valid_i;
        if (req_valid_i) begin
            st_d.addr = ptr_i;
            st_d.ptr  = ptr_i;
            case (mode)
                AGU_IND:  st_d.ptr = ptr_i;
                AGU_INC:  st_d.ptr = ptr_i + step;
                AGU_DEC:  st_d.ptr = ptr_i - step;
                AGU_MOD:  st_d.ptr = ptr_i + stride_i;
                AGU_CIRC: st_d.ptr = circ_next;
                AGU_BREV: st_d.ptr = brev_next;
                AGU_IDX:  st_d.addr = ptr_i + offset_i;
                AGU_PUSH: begin
                    st_d.addr = ptr_i - step;
                    st_d.ptr  = ptr_i - step;
                end
                default:  st_d.ptr = ptr_i;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o = st_q.vld;
    assign addr_o      = st_q.addr;
    assign ptr_wb_o    = st_q.ptr;
endmodule

// File: rtl/addr_gen_chk.sv
module addr_gen_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid_i,
    input logic [2:0]    mode_i,
    input logic [1:0]    size_i,
    input logic [AW-1:0] ptr_i,
    input logic [AW-1:0] base_i,
    input logic [AW-1:0] length_i,
    input logic          rsp_valid_o,
    input logic [AW-1:0] addr_o,
    input logic [AW-1:0] ptr_wb_o
);
    function automatic logic [AW-1:0] nbytes(input logic [1:0] c);
        nbytes = (c == 2'd0) ? AW'(1) : (c == 2'd1) ? AW'(2) : AW'(4);
    endfunction

    p_valid_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $past(req_valid_i));

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!rsp_valid_o && $stable(addr_o) && $stable(ptr_wb_o)));

    p_reset_zero_r2: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid_o && addr_o == '0 && ptr_wb_o == '0));

    p_indirect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && $past(mode_i) == 3'd0) |-> (addr_o == $past(ptr_i) && ptr_wb_o == addr_o));

    p_inc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && $past(mode_i) == 3'd1) |-> (ptr_wb_o - addr_o == nbytes($past(size_i))));

    p_post_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && ($past(mode_i) == 3'd3 || $past(mode_i) == 3'd5)) |-> addr_o == $past(ptr_i));

    p_circ_inside_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && $past(mode_i) == 3'd4 && $past(length_i) != '0
         && $past(ptr_i) >= $past(base_i) && $past(ptr_i) < $past(base_i) + $past(length_i))
        |-> (ptr_wb_o >= $past(base_i) && ptr_wb_o < $past(base_i) + $past(length_i)));

    p_index_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && $past(mode_i) == 3'd6) |-> ptr_wb_o == $past(ptr_i));

    p_push_pre_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && $past(mode_i) == 3'd7)
        |-> (addr_o == ptr_wb_o && $past(ptr_i) - addr_o == nbytes($past(size_i))));
endmodule

bind addr_gen addr_gen_chk #(.AW(AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .mode_i      (mode_i),
    .size_i      (size_i),
    .ptr_i       (ptr_i),
    .base_i      (base_i),
    .length_i    (length_i),
    .rsp_valid_o (rsp_valid_o),
    .addr_o      (addr_o),
    .ptr_wb_o    (ptr_wb_o)
);

// File: tb/addr_gen_tb_top.sv
module addr_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid_i = 1'b0;
    logic [2:0]    mode_i = '0;
    logic [1:0]    size_i = '0;
    logic [AW-1:0] ptr_i = '0, stride_i = '0, offset_i = '0, base_i = '0, length_i = '0;
    logic          rsp_valid_o;
    logic [AW-1:0] addr_o, ptr_wb_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_gen #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .mode_i(mode_i),
        .size_i(size_i), .ptr_i(ptr_i), .stride_i(stride_i), .offset_i(offset_i),
        .base_i(base_i), .length_i(length_i), .rsp_valid_o(rsp_valid_o),
        .addr_o(addr_o), .ptr_wb_o(ptr_wb_o)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one request at a falling edge; return at the next falling edge,
    // after the result has been registered.
    task automatic op(input logic [2:0] m, input logic [1:0] sz, input logic [AW-1:0] p,
                      input logic [AW-1:0] s, input logic [AW-1:0] o,
                      input logic [AW-1:0] b, input logic [AW-1:0] l);
        @(negedge clk);
        req_valid_i = 1'b1; mode_i = m; size_i = sz; ptr_i = p;
        stride_i = s; offset_i = o; base_i = b; length_i = l;
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R2 valid", AW'(rsp_valid_o), '0);
        chk("R2 addr", addr_o, '0);
        chk("R2 ptr", ptr_wb_o, '0);
    endtask

    task automatic t_indirect();
        op(3'd0, 2'd2, 32'h0000_4440, 32'h10, 32'h0, 32'h0, 32'h0);
        chk("R1 valid", AW'(rsp_valid_o), 32'd1);
        chk("R3 addr", addr_o, 32'h0000_4440);
        chk("R3 ptr", ptr_wb_o, 32'h0000_4440);
    endtask

    task automatic t_idle();
        @(negedge clk);
        chk("R1 idle valid", AW'(rsp_valid_o), '0);
        chk("R1 idle addr", addr_o, 32'h0000_4440);
        chk("R1 idle ptr", ptr_wb_o, 32'h0000_4440);
    endtask

    task automatic t_incdec();
        op(3'd1, 2'd0, 32'h100, 32'h0, 32'h0, 32'h0, 32'h0);
        chk("R4 inc b addr", addr_o, 32'h100);
        chk("R4 inc b ptr", ptr_wb_o, 32'h101);
        op(3'd1, 2'd1, 32'h100, 32'h0, 32'h0, 32'h0, 32'h0);
        chk("R4 inc h ptr", ptr_wb_o, 32'h102);
        op(3'd1, 2'd3, 32'h100, 32'h0, 32'h0, 32'h0, 32'h0);
        chk("R4 inc w ptr", ptr_wb_o, 32'h104);
        op(3'd2, 2'd2, 32'h100, 32'h0, 32'h0, 32'h0, 32'h0);
        chk("R4 dec w addr", addr_o, 32'h100);
        chk("R4 dec w ptr", ptr_wb_o, 32'h0FC);
        op(3'd2, 2'd1, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
        chk("R4 dec h wrap", ptr_wb_o, 32'hFFFF_FFFE);
    endtask

    task automatic t_postmod();
        op(3'd3, 2'd2, 32'h200, 32'hFFFF_FFF4, 32'h0, 32'h0, 32'h0);
        chk("R5 addr", addr_o, 32'h200);
        chk("R5 neg ptr", ptr_wb_o, 32'h1F4);
        op(3'd3, 2'd2, 32'h200, 32'h24, 32'h0, 32'h0, 32'h0);
        chk("R5 pos ptr", ptr_wb_o, 32'h224);
    endtask

    task automatic t_circ();
        op(3'd4, 2'd2, 32'h101C, 32'h8, 32'h0, 32'h1000, 32'h20);
        chk("R6 addr", addr_o, 32'h101C);
        chk("R6 past end", ptr_wb_o, 32'h1004);
        op(3'd4, 2'd2, 32'h1018, 32'h8, 32'h0, 32'h1000, 32'h20);
        chk("R6 at end", ptr_wb_o, 32'h1000);
        op(3'd4, 2'd2, 32'h1004, 32'hFFFF_FFF8, 32'h0, 32'h1000, 32'h20);
        chk("R6 below base", ptr_wb_o, 32'h101C);
        op(3'd4, 2'd2, 32'h1008, 32'hFFFF_FFF8, 32'h0, 32'h1000, 32'h20);
        chk("R6 at base", ptr_wb_o, 32'h1000);
        op(3'd4, 2'd2, 32'h1008, 32'h8, 32'h0, 32'h1000, 32'h20);
        chk("R6 inside", ptr_wb_o, 32'h1010);
    endtask

    task automatic t_circ_len0();
        op(3'd4, 2'd2, 32'h101C, 32'h8, 32'h0, 32'h1000, 32'h0);
        chk("R7 no wrap", ptr_wb_o, 32'h1024);
    endtask

    task automatic t_bitrev();
        logic [AW-1:0] seq [9] = '{32'd0, 32'd4, 32'd2, 32'd6, 32'd1, 32'd5, 32'd3, 32'd7, 32'd0};
        logic [AW-1:0] p = 32'd0;
        for (int i = 0; i < 8; i++) begin
            op(3'd5, 2'd2, p, 32'd4, 32'h0, 32'h0, 32'h0);
            chk("R8 addr", addr_o, seq[i]);
            chk("R8 next", ptr_wb_o, seq[i+1]);
            p = ptr_wb_o;
        end
    endtask

    task automatic t_index();
        op(3'd6, 2'd2, 32'h3000, 32'h4, 32'hFFFF_FFF8, 32'h0, 32'h0);
        chk("R9 neg addr", addr_o, 32'h2FF8);
        chk("R9 ptr kept", ptr_wb_o, 32'h3000);
        op(3'd6, 2'd2, 32'h3000, 32'h4, 32'h40, 32'h0, 32'h0);
        chk("R9 pos addr", addr_o, 32'h3040);
    endtask

    task automatic t_push();
        op(3'd7, 2'd2, 32'h2000, 32'h0, 32'h0, 32'h0, 32'h0);
        chk("R10 addr", addr_o, 32'h1FFC);
        chk("R10 ptr", ptr_wb_o, 32'h1FFC);
        op(3'd7, 2'd1, 32'h2000, 32'h0, 32'h0, 32'h0, 32'h0);
        chk("R10 half addr", addr_o, 32'h1FFE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_indirect();
        t_idle();
        t_incdec();
        t_postmod();
        t_circ();
        t_circ_len0();
        t_bitrev();
        t_index();
        t_push();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule